// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a 16-bit processor bus and an on-chip flash array while a rewrite enable input is high. Software drives it by writing command codes on the low data byte. Some commands finish in one write. Others need a confirmation write, and page programming takes a run of 128 address/data writes. The block decides what a read returns: a word from the array, the status byte, or the lock state of the block being addressed. It sends program, erase and lock operations to a behavioural array model. It keeps the error flags, and it reports the array as busy for a fixed number of cycles after each operation starts.

Reads are combinational: `bus_rdata` follows `bus_addr` and the current read selection. A write is taken on the rising clock edge when `bus_wr` is high. The array model erases to all ones. Programming ANDs the new data into the stored word, so a program can only clear bits.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and while `rewrite_en` is low, a read returns the array word at `bus_addr` (bit 0 ignored). The array resets to FFFFh everywhere and no block is locked.
- R2: Only `bus_wdata[7:0]` is decoded as a command; the value of `bus_wdata[15:8]` has no effect on which command is taken.
- R3: Command FFh selects array reads until a different command changes the selection. Command 70h selects status reads, which return {8'h00, ready, 0, erase_err, prog_err, seq_err, 3'b000}.
- R4: Command 50h clears erase_err, prog_err and seq_err and leaves the read selection unchanged.
- R5: Command 41h, followed by 128 writes to byte offsets 00h, 02h, … FEh in that order within one 256-byte page, ANDs each data word into the addressed array word. After the last write, reads select status.
- R6: During a page program, a write whose page offset is out of order, or whose page differs from the first write's page, sets seq_err, ends the sequence and selects status.
- R7: Command 20h followed by D0h erases to FFFFh every word of the block that holds the confirm address (blocks are 512 bytes). If that block is locked, nothing is erased and erase_err is set.
- R8: Command A7h followed by D0h erases every unlocked block and leaves locked blocks unchanged.
- R9: Command 77h followed by D0h locks the addressed block until reset. After command 71h, a read returns 0040h if the addressed block is unlocked and 0000h if it is locked.
- R10: If the write after 20h, A7h or 77h does not carry D0h, no operation starts, seq_err is set and status reads are selected.
- R11: For 6 cycles after an erase, a lock, or the last word of a page program is accepted, the ready bit reads 0. Writes during that time are ignored.
- R12: A page program into a locked block changes no word, sets prog_err after the 128th write, and leaves the block ready.
- R13: Clearing `rewrite_en` abandons any partly entered command, selects array reads, and causes writes to be ignored until the input is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rewrite_en | input | 1 | Rewrite mode enable |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 16 | Write data; command in bits 7:0 |
| bus_rdata | output | 16 | Read data selected by the current read mode |

## Verification
Page programming is tried with random words on random pages and with a second program over an already programmed page. The second case separates a true AND-into-array from a plain overwrite. Directed sequences cover a wrong confirm code, a skipped page offset, erasing a locked block versus an unlocked one, and erase-all with one block locked. Together these show whether lock checks are made per block or across the whole array. Command writes with junk upper bytes, writes sent while busy, and a rewrite-enable drop in the middle of a sequence show whether each of those inputs is truly ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
    localparam logic [7:0] CMD_PAGE_PROG  = 8'h41;
    localparam logic [7:0] CMD_BLK_ERASE  = 8'h20;
    localparam logic [7:0] CMD_ALL_ERASE  = 8'hA7;
    localparam logic [7:0] CMD_LOCK_SET   = 8'h77;
    localparam logic [7:0] CMD_LOCK_READ  = 8'h71;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE_CF,
        ST_ALL_CF,
        ST_LOCK_CF,
        ST_PAGE
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_LOCK
    } read_mode_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE_BLK,
        OP_ERASE_ALL,
        OP_LOCK
    } array_op_t;

    typedef struct packed {
        logic erase;
        logic prog;
        logic seq;
    } err_flags_t;

    function automatic logic [7:0] pack_status(input logic busy, input err_flags_t e);
        return {~busy, 1'b0, e.erase, e.prog, e.seq, 3'b000};
    endfunction

endpackage

// File: rtl/flash_array_model.sv
module flash_array_model
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BLK_AW = 9
) (
    input  logic                         clk,
    input  logic                         rst,
    input  array_op_t                    op,
    input  logic [ADDR_W-2:0]            op_waddr,
    input  logic [15:0]                  op_wdata,
    input  logic [ADDR_W-BLK_AW-1:0]     op_blk,
    input  logic [ADDR_W-2:0]            rd_waddr,
    output logic [15:0]                  rd_word,
    output logic [(1<<(ADDR_W-BLK_AW))-1:0] lock_q
);
    localparam int WA_W  = ADDR_W - 1;
    localparam int WORDS = 1 << WA_W;
    localparam int BK_W  = ADDR_W - BLK_AW;

    logic [15:0] mem [WORDS];

    function automatic logic [BK_W-1:0] word_blk(input int i);
        logic [WA_W-1:0] w;
        w = WA_W'(i);
        return w[WA_W-1 -: BK_W];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
            lock_q <= '0;
        end else begin
            case (op)
                OP_PROG:      mem[op_waddr] <= mem[op_waddr] & op_wdata;
                OP_ERASE_BLK: begin
                    for (int i = 0; i < WORDS; i++)
                        if (word_blk(i) == op_blk) mem[i] <= 16'hFFFF;
                end
                OP_ERASE_ALL: begin
                    for (int i = 0; i < WORDS; i++)
                        if (!lock_q[word_blk(i)]) mem[i] <= 16'hFFFF;
                end
                OP_LOCK:      lock_q[op_blk] <= 1'b1;
                default: ;
            endcase
        end
    end

    assign rd_word = mem[rd_waddr];

    // R9: a lock bit, once set, stays set until reset
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(lock_q) & ~lock_q) == '0);

    // R7: the sequencer never erases a locked block
    p_erase_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
        op == OP_ERASE_BLK |-> !lock_q[op_blk]);

    // R12: the sequencer never programs a word inside a locked block
    p_prog_unlocked_r12: assert property (@(posedge clk) disable iff (rst)
        op == OP_PROG |-> !lock_q[op_waddr[WA_W-1 -: BK_W]]);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int BLK_AW    = 9,
    parameter int PAGE_AW   = 8,
    parameter int OP_CYCLES = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rewrite_en,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [15:0]                      bus_wdata,
    input  logic [(1<<(ADDR_W-BLK_AW))-1:0]  lock_q,
    output array_op_t                        op,
    output logic [ADDR_W-2:0]                op_waddr,
    output logic [15:0]                      op_wdata,
    output logic [ADDR_W-BLK_AW-1:0]         op_blk,
    output read_mode_t                       rmode,
    output logic [7:0]                       status
);
    localparam int PC_W  = PAGE_AW - 1;
    localparam int PG_W  = ADDR_W - PAGE_AW;
    localparam int BSY_W = $clog2(OP_CYCLES + 1);
    localparam logic [PC_W-1:0]  CNT_LAST = '1;
    localparam logic [BSY_W-1:0] BSY_LOAD = BSY_W'(OP_CYCLES);

    seq_state_t        state, st_n;
    read_mode_t        rmode_q, md_n;
    err_flags_t        err, err_n;
    logic [BSY_W-1:0]  busy_cnt;
    logic              busy, start_busy;
    logic [PC_W-1:0]   page_cnt, cnt_n;
    logic [PG_W-1:0]   page_base, base_n;
    logic              page_skip, skip_n, skip_now;
    logic [7:0]        cmd;
    logic [PAGE_AW-1:0] addr_off;
    logic [PG_W-1:0]   cur_page;
    logic [ADDR_W-BLK_AW-1:0] cur_blk;
    logic              order_bad;

    assign busy     = busy_cnt != '0;
    assign cmd      = bus_wdata[7:0];
    assign addr_off = bus_addr[PAGE_AW-1:0];
    assign cur_page = bus_addr[ADDR_W-1:PAGE_AW];
    assign cur_blk  = bus_addr[ADDR_W-1:BLK_AW];
    assign order_bad = (addr_off != {page_cnt, 1'b0}) ||
                       (page_cnt != '0 && cur_page != page_base);
    assign skip_now = (page_cnt == '0) ? lock_q[cur_blk] : page_skip;

    always_comb begin
        st_n       = state;
        md_n       = rmode_q;
        err_n      = err;
        cnt_n      = page_cnt;
        base_n     = page_base;
        skip_n     = page_skip;
        start_busy = 1'b0;
        op         = OP_NONE;
        op_waddr   = bus_addr[ADDR_W-1:1];
        op_wdata   = bus_wdata;
        op_blk     = cur_blk;
        if (!rewrite_en) begin
            st_n = ST_IDLE;
            md_n = RM_ARRAY;
        end else if (bus_wr && !busy) begin
            case (state)
                ST_IDLE: begin
                    case (cmd)
                        CMD_READ_ARRAY: md_n = RM_ARRAY;
                        CMD_READ_STAT:  md_n = RM_STATUS;
                        CMD_CLEAR_STAT: err_n = '0;
                        CMD_PAGE_PROG: begin
                            st_n   = ST_PAGE;
                            cnt_n  = '0;
                            skip_n = 1'b0;
                        end
                        CMD_BLK_ERASE:  st_n = ST_ERASE_CF;
                        CMD_ALL_ERASE:  st_n = ST_ALL_CF;
                        CMD_LOCK_SET:   st_n = ST_LOCK_CF;
                        CMD_LOCK_READ:  md_n = RM_LOCK;
                        default: ;
                    endcase
                end
                ST_ERASE_CF, ST_ALL_CF, ST_LOCK_CF: begin
                    st_n = ST_IDLE;
                    md_n = RM_STATUS;
                    if (cmd != CMD_CONFIRM) begin
                        err_n.seq = 1'b1;
                    end else if (state == ST_ERASE_CF && lock_q[cur_blk]) begin
                        err_n.erase = 1'b1;
                    end else begin
                        start_busy = 1'b1;
                        op = (state == ST_ERASE_CF) ? OP_ERASE_BLK :
                             (state == ST_ALL_CF)   ? OP_ERASE_ALL : OP_LOCK;
                    end
                end
                ST_PAGE: begin
                    if (order_bad) begin
                        st_n      = ST_IDLE;
                        md_n      = RM_STATUS;
                        err_n.seq = 1'b1;
                    end else begin
                        if (page_cnt == '0) base_n = cur_page;
                        skip_n = skip_now;
                        if (!skip_now) op = OP_PROG;
                        cnt_n = page_cnt + 1'b1;
                        if (page_cnt == CNT_LAST) begin
                            st_n = ST_IDLE;
                            md_n = RM_STATUS;
                            if (skip_now) err_n.prog = 1'b1;
                            else          start_busy = 1'b1;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rmode_q   <= RM_ARRAY;
            err       <= '0;
            page_cnt  <= '0;
            page_base <= '0;
            page_skip <= 1'b0;
            busy_cnt  <= '0;
        end else begin
            state     <= st_n;
            rmode_q   <= md_n;
            err       <= err_n;
            page_cnt  <= cnt_n;
            page_base <= base_n;
            page_skip <= skip_n;
            if (start_busy)   busy_cnt <= BSY_LOAD;
            else if (busy)    busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign rmode  = rmode_q;
    assign status = pack_status(busy, err);

    // R11: a write while busy leaves sequence and read selection untouched
    p_busy_ignores_r11: assert property (@(posedge clk) disable iff (rst)
        rewrite_en && bus_wr && busy |=> state == $past(state) && rmode_q == $past(rmode_q));

    // R11: no array operation is issued while busy
    p_no_op_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> op == OP_NONE);

    // R13: leaving rewrite mode returns to idle with array reads
    p_leave_rewrite_r13: assert property (@(posedge clk) disable iff (rst)
        !rewrite_en |=> rmode_q == RM_ARRAY && state == ST_IDLE);

    // R4: clear command empties every error flag
    p_clear_flags_r4: assert property (@(posedge clk) disable iff (rst)
        rewrite_en && bus_wr && !busy && state == ST_IDLE && cmd == CMD_CLEAR_STAT
        |=> err == '0 && $stable(rmode_q));

    // R5: the page word counter moves only on an accepted write
    p_page_count_r5: assert property (@(posedge clk) disable iff (rst)
        state == ST_PAGE && rewrite_en && !bus_wr |=> $stable(page_cnt));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int BLK_AW    = 9,
    parameter int PAGE_AW   = 8,
    parameter int OP_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rewrite_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata
);
    localparam int BK_W = ADDR_W - BLK_AW;
    localparam int NBLK = 1 << BK_W;

    array_op_t          op;
    logic [ADDR_W-2:0]  op_waddr;
    logic [15:0]        op_wdata;
    logic [BK_W-1:0]    op_blk;
    logic [15:0]        rd_word;
    logic [NBLK-1:0]    lock_q;
    read_mode_t         rmode;
    logic [7:0]         status;

    flash_cmd_fsm #(
        .ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .PAGE_AW(PAGE_AW), .OP_CYCLES(OP_CYCLES)
    ) i_fsm (
        .clk(clk), .rst(rst), .rewrite_en(rewrite_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .lock_q(lock_q),
        .op(op), .op_waddr(op_waddr), .op_wdata(op_wdata), .op_blk(op_blk),
        .rmode(rmode), .status(status)
    );

    flash_array_model #(
        .ADDR_W(ADDR_W), .BLK_AW(BLK_AW)
    ) i_array (
        .clk(clk), .rst(rst), .op(op), .op_waddr(op_waddr), .op_wdata(op_wdata),
        .op_blk(op_blk), .rd_waddr(bus_addr[ADDR_W-1:1]), .rd_word(rd_word),
        .lock_q(lock_q)
    );

    always_comb begin
        if (!rewrite_en) begin
            bus_rdata = rd_word;
        end else begin
            case (rmode)
                RM_STATUS: bus_rdata = {8'h00, status};
                RM_LOCK:   bus_rdata = lock_q[bus_addr[ADDR_W-1:BLK_AW]] ? 16'h0000 : 16'h0040;
                default:   bus_rdata = rd_word;
            endcase
        end
    end

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int OPC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rewrite_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] ref_mem [1024];
    bit          ref_lock [4];
    bit          r_seq, r_prog, r_erase;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst(rst), .rewrite_en(rewrite_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5ns clk = ~clk;

    function automatic logic [15:0] exp_sr(input bit ready);
        return {8'h00, ready, 1'b0, r_erase, r_prog, r_seq, 3'b000};
    endfunction

    function automatic logic [10:0] blk_top(input int b);
        return {b[1:0], 9'h1FE};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1ns;
        d = bus_rdata;
    endtask

    task automatic wait_ready();
        repeat (OPC + 2) @(negedge clk);
    endtask

    task automatic page_prog(input int p);
        logic [15:0] d;
        wr(11'h000, 16'h0041);
        for (int w = 0; w < 128; w++) begin
            d = 16'($urandom);
            wr({p[2:0], w[6:0], 1'b0}, d);
            if (!ref_lock[p / 2]) ref_mem[p * 128 + w] = ref_mem[p * 128 + w] & d;
        end
        if (ref_lock[p / 2]) r_prog = 1;
    endtask

    task automatic erase_blk(input int b);
        wr(blk_top(b), 16'h0020);
        wr(blk_top(b), 16'h00D0);
        if (ref_lock[b]) r_erase = 1;
        else for (int i = 0; i < 256; i++) ref_mem[b * 256 + i] = 16'hFFFF;
    endtask

    task automatic erase_all();
        wr(11'h000, 16'h00A7);
        wr(11'h000, 16'h00D0);
        for (int i = 0; i < 1024; i++) if (!ref_lock[i / 256]) ref_mem[i] = 16'hFFFF;
    endtask

    task automatic cmp_words(input string tag, input int lo, input int hi, input int n);
        logic [15:0] d;
        int idx;
        wr(11'h000, 16'h00FF);
        for (int k = 0; k < n; k++) begin
            idx = lo + int'($urandom % (hi - lo));
            rd({idx[9:0], 1'b0}, d);
            chk(tag, d, ref_mem[idx]);
        end
    endtask

    initial begin
        #2000000ns;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd4711));
        for (int i = 0; i < 1024; i++) ref_mem[i] = 16'hFFFF;
        for (int b = 0; b < 4; b++) ref_lock[b] = 0;
        r_seq = 0; r_prog = 0; r_erase = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, array read with rewrite off
        rd(11'h124, d); chk("R1 reset array word", d, 16'hFFFF);
        wr(11'h000, 16'h0070);
        rd(11'h000, d); chk("R1 write ignored while rewrite off", d, 16'hFFFF);
        rewrite_en = 1'b1;
        rd(11'h002, d); chk("R1 array mode on entry", d, 16'hFFFF);

        // R2/R3: upper byte ignored, status format
        wr(11'h000, 16'hAB70);
        rd(11'h000, d); chk("R2 R3 status with junk high byte", d, 16'h0080);
        rd(11'h300, d); chk("R3 status persists", d, 16'h0080);

        // R5/R11: first page program, busy window
        page_prog(1);
        rd(11'h000, d); chk("R11 ready low after page", d, exp_sr(0));
        wr(11'h000, 16'h00FF);
        wait_ready();
        rd(11'h000, d); chk("R11 write ignored while busy", d, exp_sr(1));
        wr(11'h000, 16'h12FF);
        rd(11'h100, d); chk("R2 R3 array mode with junk high byte", d, ref_mem[128]);
        cmp_words("R5 page data", 128, 256, 16);

        // R5: second program ANDs into the stored words
        page_prog(1);
        wait_ready();
        rd(11'h000, d); chk("R5 status after page", d, exp_sr(1));
        cmp_words("R5 AND semantics", 128, 256, 16);

        // R6: out-of-order page offset
        wr(11'h000, 16'h0041);
        wr(11'h200, 16'hFFFF);
        wr(11'h204, 16'h0000);
        r_seq = 1;
        rd(11'h204, d); chk("R6 skipped offset sets seq_err", d, exp_sr(1));
        wr(11'h000, 16'h0050);
        r_seq = 0;
        rd(11'h000, d); chk("R4 clear keeps status mode", d, exp_sr(1));
        cmp_words("R6 aborted page untouched", 256, 258, 2);

        // R6: page changes mid-sequence
        wr(11'h000, 16'h0041);
        wr(11'h200, 16'hFFFF);
        wr(11'h302, 16'h0000);
        r_seq = 1;
        rd(11'h000, d); chk("R6 page change sets seq_err", d, exp_sr(1));

        // R10: bad confirm, then R4 clear
        wr(11'h000, 16'h0020);
        wr(11'h000, 16'h0055);
        rd(11'h000, d); chk("R10 bad confirm", d, exp_sr(1));
        cmp_words("R10 no erase after bad confirm", 128, 256, 4);
        wr(11'h000, 16'h0070);
        wr(11'h000, 16'h0050);
        r_seq = 0;
        rd(11'h000, d); chk("R4 clear seq_err", d, exp_sr(1));

        // R9: lock block 1 after programming page 2 (block 1)
        page_prog(2);
        wait_ready();
        wr(blk_top(1), 16'h0077);
        wr(blk_top(1), 16'h00D0);
        ref_lock[1] = 1;
        rd(11'h000, d); chk("R11 busy after lock", d, exp_sr(0));
        wait_ready();
        wr(11'h000, 16'h0071);
        rd(11'h250, d); chk("R9 locked block reads 0", d, 16'h0000);
        rd(11'h050, d); chk("R9 unlocked block reads D6", d, 16'h0040);

        // R7: erase locked block refused, unlocked block erased
        erase_blk(1);
        rd(11'h000, d); chk("R7 locked erase sets erase_err", d, exp_sr(1));
        cmp_words("R7 locked block kept", 256, 384, 8);
        erase_blk(0);
        wait_ready();
        cmp_words("R7 block 0 erased", 128, 256, 8);

        // R12: page program into locked block
        wr(11'h000, 16'h0050);
        r_erase = 0;
        page_prog(3);
        rd(11'h000, d); chk("R12 prog_err and ready", d, exp_sr(1));
        cmp_words("R12 locked page unchanged", 384, 512, 8);
        wr(11'h000, 16'h0050);
        r_prog = 0;

        // R8: erase-all skips locked blocks
        page_prog(4);
        wait_ready();
        erase_all();
        wait_ready();
        cmp_words("R8 unlocked erased", 512, 640, 8);
        cmp_words("R8 locked block kept", 256, 384, 8);

        // R13: rewrite drop mid-sequence
        page_prog(6);
        wait_ready();
        wr(blk_top(3), 16'h0020);
        @(negedge clk); rewrite_en = 1'b0;
        rd(11'h600, d); chk("R13 array read while off", d, ref_mem[768]);
        wr(blk_top(3), 16'h00D0);
        @(negedge clk); rewrite_en = 1'b1;
        rd(11'h600, d); chk("R13 array mode on return", d, ref_mem[768]);
        wr(blk_top(3), 16'h00D0);
        wait_ready();
        rd(11'h600, d); chk("R13 abandoned erase", d, ref_mem[768]);

        // Random page programs on random pages, checked against the model
        for (int it = 0; it < 6; it++) begin
            int p;
            p = int'($urandom % 8);
            page_prog(p);
            wait_ready();
            wr(11'h000, 16'h0070);
            rd(11'h000, d); chk("R5 R12 random page status", d, exp_sr(1));
            wr(11'h000, 16'h0050);
            r_prog = 0;
            cmp_words("R5 random page data", p * 128, p * 128 + 128, 6);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule